// File: doc/BRIEF.md
# Command-Driven Random Generator Register Front End

This block puts a 32-bit register interface in front of a seeded pseudo-random word generator. Software writes a command word to start a generation or a reseed. It polls a status word that shows the seeded, generating and reseeding conditions. When a generation finishes, the block latches a sticky ready flag, and software clears that flag by writing a 1 to it. The results are read back as up to eight 32-bit words. A mode bit chooses between a full refresh of all eight words and a half refresh of the first four. The generator itself is a Galois LFSR with fixed latencies. It stands in for a real entropy source and conditioner.

The block reseeds itself on its own. Each 128 bits of output counts as one unit. Once the number of units set in the auto-reseed limit register has been produced, the block reseeds. It never cuts into a generation to do so. After reset, the block seeds itself first. A generate command that arrives before seeding has finished is held and carried out once seeding completes.

The control core is a three-state machine:
- SEED: timed reseed; the reseeding status bit is set.
- IDLE: waits for a command.
- GEN: timed generation; the generating status bit is set.

Its transitions are:
- reset → SEED.
- SEED → IDLE when the seed ends and no generate is pending.
- SEED → GEN when the seed ends and a generate is pending.
- IDLE → SEED on a reseed command or when the auto-reseed limit is reached.
- IDLE → GEN on a generate command.
- GEN → SEED when the generation ends and a reseed is pending.
- GEN → IDLE when the generation ends and no reseed is pending.

Top module: `trng_cmd_regif`

## Requirements
- R1: After reset the block is in SEED: status bit 31 (reseeding) = 1 and bit 9 (seeded) = 0. When the seed completes, bit 9 becomes 1 and stays 1, and interrupt-status bit 1 (seed done, offset 0x14) is set.
- R2: Writing 1 to the command register (offset 0x00) while idle and seeded sets status bit 30 (generating) for exactly GEN_CYCLES cycles. Interrupt-status bit 0 (ready) becomes visible GEN_CYCLES clock edges after the edge that captured the write, and the result words are refreshed at the same edge.
- R3: Mode register (offset 0x08) bit 3 = 1 makes a generation refresh all eight result words at offsets 0x20, 0x24, …, 0x3C. Bit 3 = 0 refreshes only 0x20 to 0x2C, and the words at 0x30 to 0x3C keep their values.
- R4: Interrupt-status bits are set whether or not interrupts are enabled. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R5: The interrupt output is 1 only when interrupt-enable (offset 0x10) bit 31 is 1 and, for bit 0 or bit 1, both the enable and the matching status bit are 1.
- R6: Writing 2 to the command register while idle enters SEED for SEED_CYCLES cycles, with status bit 31 set, and then sets interrupt-status bit 1.
- R7: A generate command written during SEED is deferred. The generation starts when the seed ends, and status bit 30 is never set while bit 9 is 0.
- R8: The auto-reseed limit (offset 0x60) counts 16-byte units: a 128-bit generation adds 1 and a 256-bit generation adds 2. Once the count reaches a non-zero limit, SEED is entered one cycle after the generation ends, and any seed clears the count. A limit of 0 disables auto-reseed.
- R9: A reseed command written during GEN does not cut the generation short. SEED is entered at the edge where the ready flag is set.
- R10: Writing 0 (NOP) to the command register while idle changes neither the status nor the result words.
- R11: Offset 0xF0 reads 0x000046BC, and unmapped offsets read 0.
- R12: The mode, interrupt-enable and auto-reseed registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with SEED_CYCLES = 6 and GEN_CYCLES = 5, so each seed and each generation takes only a few cycles. With these values the exact-latency checks on both timers run quickly. They also let the bench chain many generations and reseeds in one run, including a reseed queued during a generation and a generate queued during the power-on seed. A small auto-reseed limit of 3 brings the point where the limit is reached within two generations, and that sequence mixes the 256-bit and 128-bit unit weights.

// File: rtl/trng_pkg.sv
package trng_pkg;
    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_IDLE = 2'd1,
        ST_GEN  = 2'd2
    } trng_state_e;

    localparam int OFS_CMD     = 'h00;
    localparam int OFS_STAT    = 'h04;
    localparam int OFS_MODE    = 'h08;
    localparam int OFS_IEN     = 'h10;
    localparam int OFS_ISTAT   = 'h14;
    localparam int OFS_WORDS   = 'h20;
    localparam int OFS_RESEED  = 'h60;
    localparam int OFS_VERSION = 'hF0;

    localparam logic [31:0] VERSION_CODE = 32'h0000_46BC;

    localparam logic [31:0] CMD_NOP  = 32'd0;
    localparam logic [31:0] CMD_GEN  = 32'd1;
    localparam logic [31:0] CMD_SEED = 32'd2;

    localparam int BIT_SEEDED  = 9;
    localparam int BIT_GENBUSY = 30;
    localparam int BIT_SEEDING = 31;
    localparam int BIT_WIDE    = 3;
endpackage

// File: rtl/trng_lfsr_core.sv
module trng_lfsr_core #(
    parameter int          WORD_W    = 32,
    parameter int          NUM_WORDS = 8,
    parameter logic [31:0] TAPS      = 32'h8020_0003,
    parameter logic [31:0] SALT      = 32'h5A17_C3E9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              seed_i,
    input  logic                              gen_i,
    input  logic                              wide_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);
    localparam int HALF = NUM_WORDS / 2;

    logic [WORD_W-1:0] state_q;
    logic [WORD_W-1:0] seed_ctr_q;
    logic [WORD_W-1:0] chain [NUM_WORDS+1];
    logic [WORD_W-1:0] reseed_val;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;

    function automatic logic [WORD_W-1:0] step(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] y;
        y = x >> 1;
        if (x[0]) y = y ^ TAPS[WORD_W-1:0];
        return y;
    endfunction

    assign chain[0] = state_q;
    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_chain
            assign chain[w+1] = step(chain[w]);
        end
    endgenerate

    always_comb begin
        reseed_val = step(state_q ^ SALT[WORD_W-1:0] ^ seed_ctr_q);
        if (reseed_val == '0) reseed_val = WORD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= WORD_W'(1);
            seed_ctr_q <= '0;
        end else if (seed_i) begin
            state_q    <= reseed_val;
            seed_ctr_q <= seed_ctr_q + WORD_W'(1);
        end else if (gen_i) begin
            state_q    <= chain[NUM_WORDS];
        end
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words_q[w] <= '0;
                end else if (gen_i && ((w < HALF) || wide_i)) begin
                    words_q[w] <= chain[w+1];
                end
            end
        end
    endgenerate

    assign words_o = words_q;

    // R3: a half-width generation leaves the top word untouched
    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_i && !wide_i) |=> (words_q[NUM_WORDS-1] == $past(words_q[NUM_WORDS-1])));
endmodule

// File: rtl/trng_reseed_ctr.sv
module trng_reseed_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             add_i,
    input  logic             wide_i,
    input  logic             clear_i,
    output logic             due_o
);
    localparam int ACC_W = CNT_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [ACC_W-1:0] count_q;
    logic [ACC_W-1:0] inc;
    logic [ACC_W:0]   sum;

    assign inc = wide_i ? ACC_W'(2) : ACC_W'(1);
    assign sum = {1'b0, count_q} + {1'b0, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (add_i) begin
            count_q <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
        end
    end

    assign due_o = (limit_i != '0) && (count_q >= {1'b0, limit_i});
endmodule

// File: rtl/trng_ctrl_fsm.sv
module trng_ctrl_fsm
    import trng_pkg::*;
#(
    parameter int SEED_CYCLES = 24,
    parameter int GEN_CYCLES  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_gen_i,
    input  logic        cmd_seed_i,
    input  logic        auto_due_i,
    output trng_state_e state_o,
    output logic        seeded_o,
    output logic        gen_start_o,
    output logic        gen_done_o,
    output logic        seed_done_o
);
    localparam int MAXC = (SEED_CYCLES > GEN_CYCLES) ? SEED_CYCLES : GEN_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] SEED_LAST = TW'(SEED_CYCLES - 1);
    localparam logic [TW-1:0] GEN_LAST  = TW'(GEN_CYCLES - 1);

    trng_state_e state_q, state_d;
    logic [TW-1:0] timer_q;
    logic seeded_q, pend_gen_q, pend_seed_q;
    logic pend_gen_d, pend_seed_d;
    logic seed_end, gen_end;

    assign seed_end = (state_q == ST_SEED) && (timer_q == SEED_LAST);
    assign gen_end  = (state_q == ST_GEN)  && (timer_q == GEN_LAST);

    always_comb begin
        state_d     = state_q;
        pend_gen_d  = pend_gen_q;
        pend_seed_d = pend_seed_q;
        unique case (state_q)
            ST_SEED: begin
                if (cmd_gen_i) pend_gen_d = 1'b1;
                pend_seed_d = 1'b0;
                if (seed_end) begin
                    if (pend_gen_q || cmd_gen_i) begin
                        state_d    = ST_GEN;
                        pend_gen_d = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (cmd_seed_i || auto_due_i) begin
                    state_d    = ST_SEED;
                    pend_gen_d = cmd_gen_i;
                end else if (cmd_gen_i) begin
                    state_d = ST_GEN;
                end
            end
            ST_GEN: begin
                if (cmd_seed_i) pend_seed_d = 1'b1;
                if (gen_end) begin
                    if (pend_seed_q || cmd_seed_i) begin
                        state_d     = ST_SEED;
                        pend_seed_d = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SEED;
            timer_q     <= '0;
            seeded_q    <= 1'b0;
            pend_gen_q  <= 1'b0;
            pend_seed_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            timer_q     <= (state_d != state_q) ? '0 : timer_q + TW'(1);
            pend_gen_q  <= pend_gen_d;
            pend_seed_q <= pend_seed_d;
            if (seed_end) seeded_q <= 1'b1;
        end
    end

    always_comb begin
        state_o     = state_q;
        seeded_o    = seeded_q;
        gen_start_o = (state_d == ST_GEN) && (state_q != ST_GEN);
        gen_done_o  = gen_end;
        seed_done_o = seed_end;
    end

    // R7: generation never runs on an unseeded generator
    p_gen_seeded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GEN) |-> seeded_q);
    // R9: a queued reseed follows the generation directly
    p_queued_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_end && pend_seed_q) |=> (state_q == ST_SEED));
    // R1: once seeded, always seeded
    p_seeded_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seeded_q |=> seeded_q);
endmodule

// File: rtl/trng_cmd_regif.sv
module trng_cmd_regif
    import trng_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_WORDS   = 8,
    parameter int CNT_W       = 16,
    parameter int SEED_CYCLES = 24,
    parameter int GEN_CYCLES  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int WORD_W = 32;

    trng_state_e state;
    logic seeded, gen_start, gen_done, seed_done, auto_due;
    logic cmd_gen, cmd_seed;
    logic mode_wide_q, wide_q;
    logic ien_glb_q;
    logic [1:0] ien_q, istat_q, istat_clr;
    logic [CNT_W-1:0] limit_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic unused_wdata;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign unused_wdata = ^bus_wdata;
    assign cmd_gen   = bus_we && hit(bus_addr, OFS_CMD) && (bus_wdata == CMD_GEN);
    assign cmd_seed  = bus_we && hit(bus_addr, OFS_CMD) && (bus_wdata == CMD_SEED);
    assign istat_clr = (bus_we && hit(bus_addr, OFS_ISTAT)) ? bus_wdata[1:0] : 2'b00;

    trng_ctrl_fsm #(
        .SEED_CYCLES (SEED_CYCLES),
        .GEN_CYCLES  (GEN_CYCLES)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_gen_i   (cmd_gen),
        .cmd_seed_i  (cmd_seed),
        .auto_due_i  (auto_due),
        .state_o     (state),
        .seeded_o    (seeded),
        .gen_start_o (gen_start),
        .gen_done_o  (gen_done),
        .seed_done_o (seed_done)
    );

    trng_reseed_ctr #(.CNT_W(CNT_W)) rctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .limit_i (limit_q),
        .add_i   (gen_done),
        .wide_i  (wide_q),
        .clear_i (seed_done),
        .due_o   (auto_due)
    );

    trng_lfsr_core #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_done),
        .gen_i   (gen_done),
        .wide_i  (wide_q),
        .words_o (words)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_wide_q <= 1'b0;
            wide_q      <= 1'b0;
            ien_glb_q   <= 1'b0;
            ien_q       <= 2'b00;
            limit_q     <= '0;
            istat_q     <= 2'b00;
        end else begin
            if (bus_we && hit(bus_addr, OFS_MODE)) mode_wide_q <= bus_wdata[BIT_WIDE];
            if (bus_we && hit(bus_addr, OFS_IEN)) begin
                ien_glb_q <= bus_wdata[31];
                ien_q     <= bus_wdata[1:0];
            end
            if (bus_we && hit(bus_addr, OFS_RESEED)) limit_q <= bus_wdata[CNT_W-1:0];
            if (gen_start) wide_q <= mode_wide_q;
            istat_q <= (istat_q & ~istat_clr) | {seed_done, gen_done};
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_CMD)) begin
            bus_rdata = (state == ST_GEN)  ? CMD_GEN :
                        (state == ST_SEED) ? CMD_SEED : CMD_NOP;
        end else if (hit(bus_addr, OFS_STAT)) begin
            bus_rdata[BIT_SEEDED]  = seeded;
            bus_rdata[BIT_GENBUSY] = (state == ST_GEN);
            bus_rdata[BIT_SEEDING] = (state == ST_SEED);
        end else if (hit(bus_addr, OFS_MODE)) begin
            bus_rdata[BIT_WIDE] = mode_wide_q;
        end else if (hit(bus_addr, OFS_IEN)) begin
            bus_rdata[31]  = ien_glb_q;
            bus_rdata[1:0] = ien_q;
        end else if (hit(bus_addr, OFS_ISTAT)) begin
            bus_rdata[1:0] = istat_q;
        end else if (hit(bus_addr, OFS_RESEED)) begin
            bus_rdata[CNT_W-1:0] = limit_q;
        end else if (hit(bus_addr, OFS_VERSION)) begin
            bus_rdata = VERSION_CODE;
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (hit(bus_addr, OFS_WORDS + 4 * i)) bus_rdata = words[i];
            end
        end
    end

    assign irq_o = ien_glb_q && |(ien_q & istat_q);

    // R2: ready flag only rises after a finished generation
    p_ready_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_q[0]) |-> $past(gen_done));
    // R5: no interrupt without the global enable
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ien_glb_q);
    // R4: write-1 clears the ready flag when no new completion coincides
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit(bus_addr, OFS_ISTAT) && bus_wdata[0] && !gen_done) |=> !istat_q[0]);
    // R8: a reached limit while idle starts a seed next cycle
    p_auto_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_due && state == ST_IDLE) |=> (state == ST_SEED));
endmodule

// File: tb/trng_cmd_regif_tb_top.sv
module trng_cmd_regif_tb_top;
    localparam int SEEDC = 6;
    localparam int GENC  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    trng_cmd_regif #(
        .ADDR_W(8), .NUM_WORDS(8), .CNT_W(16),
        .SEED_CYCLES(SEEDC), .GEN_CYCLES(GENC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_bit(input logic [7:0] a, input int b, input logic val, output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            rd(a, v);
            if (v[b] == val || n > 200) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int guard = 0;
        forever begin
            rd(8'h04, v);
            if (!v[30] && !v[31]) break;
            if (guard > 200) break;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic snap(output logic [31:0] s [8]);
        for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), s[i]);
    endtask

    task automatic t_reset_and_defer();
        logic [31:0] v;
        int n;
        rd(8'h04, v);
        chk(v[31] == 1'b1 && v[9] == 1'b0, "R1 reset seeding", v, 32'h8000_0000);
        wr(8'h00, 32'd1);
        rd(8'h04, v);
        chk(v[31] == 1'b1 && v[30] == 1'b0, "R7 generate deferred in seed", v, 32'h8000_0000);
        wait_bit(8'h14, 0, 1'b1, n);
        rd(8'h14, v);
        chk(v[1:0] == 2'b11, "R1 seed-done and R7 deferred ready", v, 32'h3);
        rd(8'h04, v);
        chk(v[9] == 1'b1, "R1 seeded after seed", v, 32'h200);
        rd(8'h24, v);
        chk(v != 0, "R3 low word refreshed", v, 32'h1);
        rd(8'h30, v);
        chk(v == 0, "R3 upper word kept in narrow mode", v, 32'h0);
    endtask

    task automatic t_w1c_irq();
        logic [31:0] v;
        wr(8'h14, 32'h1);
        rd(8'h14, v);
        chk(v[1:0] == 2'b10, "R4 clear ready only", v, 32'h2);
        wr(8'h14, 32'h0);
        rd(8'h14, v);
        chk(v[1:0] == 2'b10, "R4 write 0 no effect", v, 32'h2);
        chk(irq_o == 1'b0, "R5 no irq when disabled", {31'b0, irq_o}, 32'h0);
        wr(8'h10, 32'h0000_0002);
        chk(irq_o == 1'b0, "R5 no irq without global", {31'b0, irq_o}, 32'h0);
        wr(8'h10, 32'h8000_0001);
        chk(irq_o == 1'b0, "R5 ready enable with ready clear", {31'b0, irq_o}, 32'h0);
        wr(8'h10, 32'h8000_0002);
        chk(irq_o == 1'b1, "R5 seed-done irq", {31'b0, irq_o}, 32'h1);
        rd(8'h10, v);
        chk(v == 32'h8000_0002, "R12 enable readback", v, 32'h8000_0002);
        wr(8'h14, 32'h2);
        chk(irq_o == 1'b0, "R5 irq drops after clear", {31'b0, irq_o}, 32'h0);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_gen_timing();
        logic [31:0] v;
        int n;
        wr(8'h00, 32'd1);
        rd(8'h04, v);
        chk(v[30] == 1'b1 && v[31] == 1'b0, "R2 generating set", v, 32'h4000_0200);
        wait_bit(8'h14, 0, 1'b1, n);
        chk(n == GENC, "R2 generation latency", 32'(n), 32'(GENC));
        rd(8'h04, v);
        chk(v[30] == 1'b0, "R2 generating cleared", v, 32'h200);
        wr(8'h14, 32'h3);
    endtask

    task automatic t_modes();
        logic [31:0] a [8];
        logic [31:0] b [8];
        logic [31:0] v;
        int n;
        wr(8'h08, 32'h8);
        rd(8'h08, v);
        chk(v == 32'h8, "R12 mode readback", v, 32'h8);
        snap(a);
        wr(8'h00, 32'd1);
        wait_bit(8'h14, 0, 1'b1, n);
        snap(b);
        for (int i = 0; i < 8; i++)
            chk(a[i] != b[i], "R3 wide refresh", b[i], ~a[i]);
        wr(8'h14, 32'h1);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'd1);
        wait_bit(8'h14, 0, 1'b1, n);
        snap(a);
        for (int i = 0; i < 4; i++)
            chk(a[i] != b[i], "R3 narrow refresh low", a[i], ~b[i]);
        for (int i = 4; i < 8; i++)
            chk(a[i] == b[i], "R3 narrow hold high", a[i], b[i]);
        wr(8'h14, 32'h1);
    endtask

    task automatic t_nop();
        logic [31:0] a [8];
        logic [31:0] b [8];
        logic [31:0] s0, s1;
        rd(8'h04, s0);
        snap(a);
        wr(8'h00, 32'd0);
        @(negedge clk);
        rd(8'h04, s1);
        snap(b);
        chk(s1 == s0, "R10 nop status", s1, s0);
        for (int i = 0; i < 8; i++)
            chk(a[i] == b[i], "R10 nop words", b[i], a[i]);
    endtask

    task automatic t_seed_cmd();
        logic [31:0] v;
        int n;
        wr(8'h00, 32'd2);
        rd(8'h04, v);
        chk(v[31] == 1'b1, "R6 reseeding set", v, 32'h8000_0200);
        wait_bit(8'h14, 1, 1'b1, n);
        chk(n == SEEDC, "R6 seed latency", 32'(n), 32'(SEEDC));
        wr(8'h14, 32'h3);
    endtask

    task automatic t_seed_during_gen();
        logic [31:0] v;
        int n;
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd2);
        rd(8'h04, v);
        chk(v[30] == 1'b1 && v[31] == 1'b0, "R9 generation continues", v, 32'h4000_0200);
        wait_bit(8'h14, 0, 1'b1, n);
        rd(8'h04, v);
        chk(v[31] == 1'b1 && v[30] == 1'b0, "R9 seed after generation", v, 32'h8000_0200);
        wait_idle();
        wr(8'h14, 32'h3);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        int n;
        wr(8'h00, 32'd2);
        wait_idle();
        wr(8'h60, 32'd3);
        rd(8'h60, v);
        chk(v == 32'd3, "R12 limit readback", v, 32'd3);
        wr(8'h14, 32'h3);
        wr(8'h08, 32'h8);
        wr(8'h00, 32'd1);
        wait_bit(8'h14, 0, 1'b1, n);
        @(negedge clk);
        rd(8'h04, v);
        chk(v[31] == 1'b0, "R8 below limit no reseed", v, 32'h200);
        wr(8'h14, 32'h1);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'd1);
        wait_bit(8'h14, 0, 1'b1, n);
        @(negedge clk);
        rd(8'h04, v);
        chk(v[31] == 1'b1, "R8 auto reseed at limit", v, 32'h8000_0200);
        wait_bit(8'h14, 1, 1'b1, n);
        rd(8'h14, v);
        chk(v[1] == 1'b1, "R8 auto seed done", v, 32'h3);
        wait_idle();
        wr(8'h60, 32'd0);
        wr(8'h08, 32'h8);
        for (int k = 0; k < 3; k++) begin
            wr(8'h14, 32'h3);
            wr(8'h00, 32'd1);
            wait_bit(8'h14, 0, 1'b1, n);
            @(negedge clk);
            rd(8'h04, v);
            chk(v[31] == 1'b0, "R8 limit zero disables", v, 32'h200);
        end
    endtask

    task automatic t_version();
        logic [31:0] v;
        rd(8'hF0, v);
        chk(v == 32'h0000_46BC, "R11 version", v, 32'h0000_46BC);
        rd(8'h40, v);
        chk(v == 32'h0, "R11 unmapped", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_defer();
        t_w1c_irq();
        t_gen_timing();
        t_modes();
        t_nop();
        t_seed_cmd();
        t_seed_during_gen();
        t_auto();
        t_version();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule